// File: doc/BRIEF.md
# Half-Duplex Collision and Carrier Sense Generator

This block drives the collision (`col`) and carrier sense (`crs`) indications of a media-independent interface. It takes internal transmit-active and receive-active levels, a bit-time strobe, a speed select, a duplex select and a heartbeat enable. In half duplex it reports carrier for either direction. It flags a collision when both directions are active at once. How soon that collision is reported depends on which direction started first.

A collision that begins while a 10 Mb/s transmit is already running must persist for a set number of bit times before `col` rises. This keeps short bursts of noise from being reported as collisions. A collision that begins with a receive in progress, or any collision at 100 Mb/s, is reported straight away. After each 10 Mb/s transmit the block can also place a signal-quality-error heartbeat pulse on `col`. In full duplex, carrier follows receive only and `col` stays low. Signal detection and decoding happen upstream; the activity levels arrive already qualified.

Top module: `mii_col_crs`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it, `col` and `crs` are 0.
- R2: With `full_duplex`=0, `crs` is 1 after a rising clock edge exactly when `tx_active` or `rx_active` was 1 at that edge, and 0 otherwise. Carrier therefore drops at the first edge after both activities end.
- R3: With `full_duplex`=1, `crs` after an edge equals `rx_active` at that edge; transmit activity has no effect on it.
- R4: With `full_duplex`=1 at an edge, `col` is 0 after that edge, whatever the activity levels, speed or heartbeat enable.
- R5: A collision is `full_duplex`=0 with `tx_active`=1 and `rx_active`=1. Its onset is the first edge at which this holds. The collision is transmit-origin only when, one edge before the onset, `tx_active` was 1 and `rx_active` was 0, and `speed_100`=0. Any other collision (receive first, both starting together, or `speed_100`=1) sets `col` at the onset edge.
- R6: For a transmit-origin collision, `col` rises at the edge that samples the seventh `bit_tick` after the onset edge. A tick sampled at the onset edge itself does not count. `col` then stays 1 while the collision lasts.
- R7: `col` due to a collision returns to 0 at the first edge at which the collision condition no longer holds.
- R8: If a transmit-origin collision ends before its seventh tick, the tick count is discarded. A later collision starts counting from zero, and `col` stays 0 throughout the interrupted one.
- R9: With `hb_enable`=1, `speed_100`=0 and `full_duplex`=0, a falling `tx_active` starts a heartbeat. `col` rises at the edge that samples the tenth `bit_tick` after the edge that saw `tx_active` low. It falls at the edge that samples the twentieth such tick. A new transmit or a mode change cancels it.
- R10: No heartbeat pulse follows a transmit when `speed_100`=1 or `hb_enable`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_active | input | 1 | Local transmit in progress |
| rx_active | input | 1 | Receive activity detected |
| speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| full_duplex | input | 1 | 1 selects full duplex, 0 half duplex |
| hb_enable | input | 1 | Enables the post-transmit heartbeat |
| col | output | 1 | Collision indication (includes heartbeat) |
| crs | output | 1 | Carrier sense |

## Verification
Carrier and an immediate collision are due at the same edge that samples the new inputs. A qualified collision is due at the edge that samples the seventh counted tick. The heartbeat edges fall on the tenth and twentieth ticks after the transmit ends. The bench drives one cycle of inputs at each falling edge and queues the output values the requirements predict for the next rising edge. A monitor takes each entry one time unit after that edge and compares. This keeps every comparison pinned to the single cycle in which the result must appear. Tick-driven sequences are laid out one strobe per driven cycle, so the due cycle can be counted directly.

// File: rtl/mii_cc_pkg.sv
package mii_cc_pkg;

   typedef enum logic [1:0] {
      HB_IDLE  = 2'd0,
      HB_WAIT  = 2'd1,
      HB_PULSE = 2'd2
   } hb_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cc_carrier.sv
module cc_carrier (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_active,
   input  logic rx_active,
   input  logic full_duplex,
   output logic crs
);

   logic crs_next;

   // Full duplex: only the receive side counts as carrier.
   always_comb begin
      if (full_duplex) crs_next = rx_active;
      else             crs_next = tx_active | rx_active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crs <= 1'b0;
      else        crs <= crs_next;
   end

endmodule

// File: rtl/cc_collision.sv
module cc_collision #(
   parameter int QUAL_BITS = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_active,
   input  logic rx_active,
   input  logic speed_100,
   input  logic full_duplex,
   output logic coll_col
);

   localparam int           CW   = $clog2(QUAL_BITS + 1);
   localparam logic [CW-1:0] QMAX = CW'(QUAL_BITS);
   localparam logic [CW-1:0] QLST = CW'(QUAL_BITS - 1);

   logic          tx_d, rx_d, coll_d, held;
   logic [CW-1:0] cnt;
   logic          coll_now, onset, tx_origin, qual_ok;

   assign coll_now  = ~full_duplex & tx_active & rx_active;
   assign onset     = coll_now & ~coll_d;
   // Transmit was already running alone before receive joined, at 10 Mb/s.
   assign tx_origin = tx_d & ~rx_d & ~speed_100;

   always_comb begin
      if (onset)      qual_ok = ~tx_origin;
      else if (!held) qual_ok = 1'b1;
      else            qual_ok = (cnt == QMAX) || (bit_tick && cnt == QLST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_d     <= 1'b0;
         rx_d     <= 1'b0;
         coll_d   <= 1'b0;
         held     <= 1'b0;
         cnt      <= '0;
         coll_col <= 1'b0;
      end else begin
         tx_d     <= tx_active;
         rx_d     <= rx_active;
         coll_d   <= coll_now;
         coll_col <= coll_now & qual_ok;
         if (!coll_now) begin
            held <= 1'b0;
            cnt  <= '0;
         end else if (onset) begin
            held <= tx_origin;
            cnt  <= '0;
         end else if (held && bit_tick && cnt != QMAX) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cc_heartbeat.sv
module cc_heartbeat
   import mii_cc_pkg::*;
#(
   parameter int DELAY_TICKS = 10,
   parameter int PULSE_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_active,
   input  logic speed_100,
   input  logic full_duplex,
   input  logic hb_enable,
   output logic sqe
);

   localparam int            SPAN = max_of(DELAY_TICKS, PULSE_TICKS);
   localparam int            CW   = $clog2(SPAN + 1);
   localparam logic [CW-1:0] DLST = CW'(DELAY_TICKS - 1);
   localparam logic [CW-1:0] PLST = CW'(PULSE_TICKS - 1);

   hb_state_t     state;
   logic [CW-1:0] cnt;
   logic          tx_d, allowed, tx_end;

   assign allowed = hb_enable & ~speed_100 & ~full_duplex;
   assign tx_end  = tx_d & ~tx_active;
   assign sqe     = (state == HB_PULSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= HB_IDLE;
         cnt   <= '0;
         tx_d  <= 1'b0;
      end else begin
         tx_d <= tx_active;
         if (!allowed || tx_active) begin
            state <= HB_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               HB_IDLE: begin
                  if (tx_end) begin
                     state <= HB_WAIT;
                     cnt   <= '0;
                  end
               end
               HB_WAIT: begin
                  if (bit_tick) begin
                     if (cnt == DLST) begin
                        state <= HB_PULSE;
                        cnt   <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               HB_PULSE: begin
                  if (bit_tick) begin
                     if (cnt == PLST) begin
                        state <= HB_IDLE;
                        cnt   <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: begin
                  state <= HB_IDLE;
                  cnt   <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/mii_col_crs.sv
module mii_col_crs #(
   parameter int QUAL_BITS   = 7,
   parameter int HB_DELAY    = 10,
   parameter int HB_LEN      = 10,
   parameter bit HB_PRESENT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_active,
   input  logic rx_active,
   input  logic speed_100,
   input  logic full_duplex,
   input  logic hb_enable,
   output logic col,
   output logic crs
);

   initial begin
      assert (QUAL_BITS >= 1) else $error("QUAL_BITS must be at least 1");
      assert (HB_DELAY >= 1)  else $error("HB_DELAY must be at least 1");
      assert (HB_LEN >= 1)    else $error("HB_LEN must be at least 1");
   end

   logic coll_col, sqe;

   cc_carrier u_carrier (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_active   (tx_active),
      .rx_active   (rx_active),
      .full_duplex (full_duplex),
      .crs         (crs)
   );

   cc_collision #(.QUAL_BITS(QUAL_BITS)) u_collision (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick    (bit_tick),
      .tx_active   (tx_active),
      .rx_active   (rx_active),
      .speed_100   (speed_100),
      .full_duplex (full_duplex),
      .coll_col    (coll_col)
   );

   generate
      if (HB_PRESENT) begin : g_hb
         cc_heartbeat #(.DELAY_TICKS(HB_DELAY), .PULSE_TICKS(HB_LEN)) u_hb (
            .clk         (clk),
            .rst_n       (rst_n),
            .bit_tick    (bit_tick),
            .tx_active   (tx_active),
            .speed_100   (speed_100),
            .full_duplex (full_duplex),
            .hb_enable   (hb_enable),
            .sqe         (sqe)
         );
      end else begin : g_no_hb
         logic unused_hb;
         assign unused_hb = hb_enable;
         assign sqe       = 1'b0;
      end
   endgenerate

   assign col = coll_col | sqe;

endmodule

// File: rtl/mii_col_crs_chk.sv
module mii_col_crs_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_active,
   input logic rx_active,
   input logic speed_100,
   input logic full_duplex,
   input logic col,
   input logic crs
);

   logic [1:0] age;
   logic       ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end
   assign ok = (age == 2'd2);

   p_crs_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !$past(full_duplex) |-> crs == ($past(tx_active) || $past(rx_active)));

   p_crs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ok && $past(full_duplex) |-> crs == $past(rx_active));

   p_no_col_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ok && $past(full_duplex) |-> !col);

   p_fast_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ok && $past(speed_100) && $past(!full_duplex && tx_active && rx_active) |-> col);

   p_quiet_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ok && $past(speed_100) && !$past(tx_active && rx_active) |-> !col);

endmodule

bind mii_col_crs mii_col_crs_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_active   (tx_active),
   .rx_active   (rx_active),
   .speed_100   (speed_100),
   .full_duplex (full_duplex),
   .col         (col),
   .crs         (crs)
);

// File: tb/sim_mii_col_crs.sv
`timescale 1ns/1ps
module sim_mii_col_crs;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0, tx_active = 1'b0, rx_active = 1'b0;
   logic speed_100 = 1'b0, full_duplex = 1'b0, hb_enable = 1'b0;
   logic col, crs;

   bit m_spd = 1'b0, m_fd = 1'b0, m_hb = 1'b0;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   typedef struct {
      bit    ec;
      bit    es;
      string req;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   mii_col_crs u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_active(tx_active),
      .rx_active(rx_active), .speed_100(speed_100), .full_duplex(full_duplex),
      .hb_enable(hb_enable), .col(col), .crs(crs)
   );

   task automatic step(input bit tk, input bit tx, input bit rx,
                       input bit ec, input bit es, input string req);
      exp_t e;
      @(negedge clk);
      speed_100   = m_spd;
      full_duplex = m_fd;
      hb_enable   = m_hb;
      bit_tick    = tk;
      tx_active   = tx;
      rx_active   = rx;
      e.ec = ec; e.es = es; e.req = req;
      sb.push_back(e);
   endtask

   // Monitor: one expectation per rising edge, sampled just after it.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (col !== e.ec || crs !== e.es) begin
               failures++;
               $display("FAIL %s: col=%0b crs=%0b expected col=%0b crs=%0b at %0t",
                        e.req, col, crs, e.ec, e.es, $time);
            end
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R1: outputs held low under reset despite active inputs
      tx_active = 1'b1; rx_active = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (col !== 1'b0 || crs !== 1'b0) begin
         failures++;
         $display("FAIL R1: col=%0b crs=%0b expected col=0 crs=0", col, crs);
      end
      @(negedge clk);
      tx_active = 1'b0; rx_active = 1'b0;
      rst_n = 1'b1;
      step(0,0,0,0,0,"R1");

      // R2: receive-only carrier, drop after end of packet
      step(0,0,0,0,0,"R2");
      repeat (3) step(0,0,1,0,1,"R2");
      step(0,0,0,0,0,"R2");

      // R5: receive first, collision reported at once at 10 Mb/s
      step(0,0,1,0,1,"R2");
      repeat (3) step(1,1,1,1,1,"R5");
      step(0,0,1,0,1,"R7");
      step(0,0,0,0,0,"R2");

      // R6: transmit first, seven counted ticks
      step(0,1,0,0,1,"R2");
      step(0,1,0,0,1,"R2");
      step(1,1,1,0,1,"R6");            // onset tick is not counted
      for (int i = 1; i <= 7; i++) begin
         step(1,1,1,(i == 7),1,"R6");
         step(0,1,1,(i == 7),1,"R6");
      end
      repeat (2) step(1,1,1,1,1,"R6");
      step(0,1,0,0,1,"R7");

      // R8: interrupted qualification restarts from zero
      step(0,1,1,0,1,"R8");
      repeat (4) step(1,1,1,0,1,"R8");
      step(0,1,0,0,1,"R8");
      step(0,1,1,0,1,"R8");
      repeat (6) step(1,1,1,0,1,"R8");
      step(1,1,1,1,1,"R6");
      step(0,0,0,0,0,"R7");

      // R5 / R10 at 100 Mb/s: immediate collision, no heartbeat
      m_spd = 1'b1; m_hb = 1'b1;
      step(0,1,0,0,1,"R2");
      step(0,1,1,1,1,"R5");
      repeat (3) step(1,1,1,1,1,"R5");
      step(0,1,0,0,1,"R7");
      step(0,0,0,0,0,"R10");
      repeat (25) step(1,0,0,0,0,"R10");

      // R10: heartbeat disabled at 10 Mb/s
      m_spd = 1'b0; m_hb = 1'b0;
      step(0,1,0,0,1,"R2");
      step(0,0,0,0,0,"R10");
      repeat (25) step(1,0,0,0,0,"R10");

      // R9: heartbeat after a 10 Mb/s transmit
      m_hb = 1'b1;
      step(0,1,0,0,1,"R2");
      step(0,0,0,0,0,"R9");
      for (int i = 1; i <= 25; i++)
         step(1,0,0,(i >= 10 && i < 20),0,"R9");

      // R3 / R4: full duplex
      m_fd = 1'b1;
      step(0,1,0,0,0,"R3");
      repeat (10) step(1,1,1,0,1,"R4");
      step(0,1,0,0,0,"R3");
      step(0,0,0,0,0,"R4");
      repeat (25) step(1,0,0,0,0,"R4");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule